// File: doc/BRIEF.md
# Artificial Trigger Ratio Sequencer

This block produces artificial triggers for a detector trigger system. One interval timer, counted in milliseconds, is shared by every artificial trigger kind. Each time the interval runs out the block serves one slot. The slot goes to one of three trigger kinds: pedestal, internal light pulse or external light-pulse calibration. The kinds take turns in a fixed order. Each kind keeps the turn for a programmable number of consecutive slots before handing it on.

A packed ratio word sets how many slots each kind receives per round. A settings byte holds an enable bit for each kind and a common veto. A kind that is disabled, or whose count is zero, is passed over. Passing over a kind does not use up any interval time. When the run input is low, the sequencer rests: the timer is cleared and the next round starts at the pedestal kind. Every served slot appears on the output as a one-cycle pulse together with a two-bit kind code.

Top module: `art_trig_seq`

## Requirements
- R1: While `rstN` or `runEn` is low, `trigPulse` is 0 and `trigType` is 0. A cycle after `runEn` falls, no pulse appears.
- R2: Let P be the parameter `CLK_PER_MS` and N the value of `intervalMs`. After `runEn` rises, slots fall every N×P cycles. The first slot's pulse is visible after the N×P-th rising edge at which `runEn` is high.
- R3: An `intervalMs` of 0 behaves exactly like an interval of 1 ms.
- R4: Kinds are served in the cyclic order pedestal, internal, external. `trigType` carries code 0 for pedestal, 1 for internal and 2 for external. When no pulse is present, `trigType` is 0.
- R5: `ratioWord` bits 14:10 give the pedestal count, bits 9:5 the internal count and bits 4:0 the external count. A kind keeps consecutive slots until its count is reached.
- R6: `genSettings` bit 6 enables pedestal, bit 5 enables internal and bit 4 enables external. A disabled kind is passed over within the same slot, so the slot goes to the next eligible kind.
- R7: A kind whose count is zero is passed over in the same way as a disabled kind.
- R8: When no kind is eligible, no pulse is produced.
- R9: While `genSettings` bit 1 (veto) is high, a slot still advances the sequence, but its pulse is suppressed.
- R10: After a stop, the next run begins at the pedestal kind, with a fresh timer and a fresh repeat count.
- R11: `trigPulse` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | High to run the sequencer; low stops it and clears its state |
| genSettings | input | 8 | Bit 6/5/4: pedestal/internal/external enable; bit 1: veto |
| intervalMs | input | 10 | Slot interval in milliseconds (0 acts as 1) |
| ratioWord | input | 16 | Packed slot counts per kind: 14:10 pedestal, 9:5 internal, 4:0 external |
| trigPulse | output | 1 | One-cycle artificial trigger pulse |
| trigType | output | 2 | Kind of the current pulse: 0 pedestal, 1 internal, 2 external |

## Verification
The single-cycle-pulse property assumes that `CLK_PER_MS` is at least 2, so two slots can never be adjacent. The bench uses 8. The veto and stop properties assume those inputs stay steady around a clock edge. The stimulus changes every input only at falling edges. Random configurations keep intervals between 0 and 3 ms and counts below 4. This keeps each round short enough that wrap-around, skipping and mid-run configuration changes all happen many times.

// File: rtl/art_trig_pkg.sv
package art_trig_pkg;
  localparam int NUM_KINDS = 3;
  localparam int KIND_W    = 2;
  localparam int CNT_W     = 5;
  localparam int IVL_W     = 10;
  localparam int SET_W     = 8;
  localparam int RATIO_W   = 16;
  localparam int EN_TOP    = 6;   // enable of kind 0 (pedestal); kind k at EN_TOP-k
  localparam int VETO_BIT  = 1;

  typedef enum logic [KIND_W-1:0] {
    KIND_PED   = 2'd0,
    KIND_LPINT = 2'd1,
    KIND_LPEXT = 2'd2
  } kind_e;

  typedef struct packed {
    logic clear;   // hold timers at zero
    logic count;   // advance timers
  } tmr_ctrl_t;
endpackage

// File: rtl/art_trig_timer.sv
module art_trig_timer
  import art_trig_pkg::*;
#(
  parameter int CLK_PER_MS = 250000
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_ctrl_t        tmrCtrl,
  input  logic [IVL_W-1:0] intervalMs,
  output logic             slotDue
);
  localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);

  logic [PRE_W-1:0] preCnt;
  logic [IVL_W-1:0] msCnt;
  logic [IVL_W-1:0] effIvl;
  logic             msTick;

  assign effIvl  = (intervalMs == '0) ? IVL_W'(1) : intervalMs;
  assign msTick  = tmrCtrl.count && (preCnt == PRE_LAST);
  assign slotDue = msTick && (msCnt >= effIvl - IVL_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else if (tmrCtrl.clear) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else if (tmrCtrl.count) begin
      preCnt <= msTick ? '0 : preCnt + PRE_W'(1);
      if (msTick) msCnt <= slotDue ? '0 : msCnt + IVL_W'(1);
    end
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= PRE_LAST) else $error("prescaler out of range"); // R2

  AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    tmrCtrl.clear |=> (preCnt == '0 && msCnt == '0)) else $error("timer not cleared"); // R10
endmodule

// File: rtl/art_trig_ctrl.sv
module art_trig_ctrl
  import art_trig_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               runEn,
  input  logic [SET_W-1:0]   genSettings,
  input  logic [RATIO_W-1:0] ratioWord,
  input  logic               slotDue,
  output tmr_ctrl_t          tmrCtrl,
  output logic               trigPulse,
  output logic [KIND_W-1:0]  trigType
);
  logic [NUM_KINDS-1:0] eligible;
  logic [CNT_W-1:0]     kindCnt [NUM_KINDS];
  logic [KIND_W-1:0]    kindPtr;
  logic [CNT_W-1:0]     repCnt;
  logic [KIND_W-1:0]    pickKind;
  logic                 pickFound;
  logic                 repDone;
  logic [KIND_W-1:0]    nextPtr;
  logic                 veto;

  // Ratio fields: kind 0 in the highest field, kind 2 in the lowest.
  for (genvar g = 0; g < NUM_KINDS; g++) begin : g_kind
    assign kindCnt[g]  = ratioWord[(NUM_KINDS-1-g)*CNT_W +: CNT_W];
    assign eligible[g] = genSettings[EN_TOP-g] && (kindCnt[g] != '0);
  end

  assign veto = genSettings[VETO_BIT];
  assign tmrCtrl.clear = !runEn;
  assign tmrCtrl.count = runEn;

  // First eligible kind at or after the pointer, in cyclic order.
  always_comb begin
    pickKind  = kindPtr;
    pickFound = 1'b0;
    for (int k = NUM_KINDS - 1; k >= 0; k--) begin
      int idx;
      idx = int'(kindPtr) + k;
      if (idx >= NUM_KINDS) idx = idx - NUM_KINDS;
      if (eligible[idx]) begin
        pickFound = 1'b1;
        pickKind  = KIND_W'(idx);
      end
    end
  end

  assign repDone = ({1'b0, repCnt} + (CNT_W+1)'(1)) >= {1'b0, kindCnt[pickKind]};
  assign nextPtr = (pickKind == KIND_W'(NUM_KINDS - 1)) ? '0 : pickKind + KIND_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindPtr   <= KIND_PED;
      repCnt    <= '0;
      trigPulse <= 1'b0;
      trigType  <= '0;
    end else if (!runEn) begin
      kindPtr   <= KIND_PED;
      repCnt    <= '0;
      trigPulse <= 1'b0;
      trigType  <= '0;
    end else begin
      trigPulse <= 1'b0;
      trigType  <= '0;
      if (slotDue && pickFound) begin
        trigPulse <= !veto;
        trigType  <= veto ? '0 : pickKind;
        if (repDone) begin
          kindPtr <= nextPtr;
          repCnt  <= '0;
        end else begin
          kindPtr <= pickKind;
          repCnt  <= repCnt + CNT_W'(1);
        end
      end
    end
  end

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !trigPulse) else $error("pulse while stopped"); // R1

  AST_VETO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    veto |=> !trigPulse) else $error("pulse under veto"); // R9

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse) else $error("pulse wider than one cycle"); // R11

  AST_PULSE_ON_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> $past(slotDue)) else $error("pulse without slot"); // R2

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> (trigType < KIND_W'(NUM_KINDS))) else $error("illegal kind code"); // R4

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    kindPtr < KIND_W'(NUM_KINDS)) else $error("pointer out of range"); // R4
endmodule

// File: rtl/art_trig_seq.sv
module art_trig_seq
  import art_trig_pkg::*;
#(
  parameter int CLK_PER_MS = 250000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic [7:0]  genSettings,
  input  logic [9:0]  intervalMs,
  input  logic [15:0] ratioWord,
  output logic        trigPulse,
  output logic [1:0]  trigType
);
  tmr_ctrl_t tmrCtrl;
  logic      slotDue;

  art_trig_timer #(.CLK_PER_MS(CLK_PER_MS)) u_timer (
    .clk        (clk),
    .rstN       (rstN),
    .tmrCtrl    (tmrCtrl),
    .intervalMs (intervalMs),
    .slotDue    (slotDue)
  );

  art_trig_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .runEn       (runEn),
    .genSettings (genSettings),
    .ratioWord   (ratioWord),
    .slotDue     (slotDue),
    .tmrCtrl     (tmrCtrl),
    .trigPulse   (trigPulse),
    .trigType    (trigType)
  );
endmodule

// File: tb/sim_art_trig_seq.sv
`timescale 1ns/1ps
module sim_art_trig_seq;
  localparam int P = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic [7:0]  genSettings = '0;
  logic [9:0]  intervalMs = '0;
  logic [15:0] ratioWord = '0;
  logic        trigPulse;
  logic [1:0]  trigType;

  int checks = 0;
  int errors = 0;
  int mPre = 0, mMs = 0, mPtr = 0, mRep = 0;
  bit expPulse = 0;
  int expType = 0;
  int seen [3];

  always #2 clk = ~clk;

  art_trig_seq #(.CLK_PER_MS(P)) u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .genSettings(genSettings),
    .intervalMs(intervalMs), .ratioWord(ratioWord),
    .trigPulse(trigPulse), .trigType(trigType)
  );

  function automatic int fieldCnt(input int k, input logic [15:0] r);
    return int'((r >> ((2 - k) * 5)) & 16'h1f);
  endfunction

  function automatic int pickKind(input int ptr, input logic [7:0] s, input logic [15:0] r);
    for (int off = 0; off < 3; off++) begin
      int k;
      k = (ptr + off) % 3;
      if (s[6 - k] && fieldCnt(k, r) != 0) return k;
    end
    return -1;
  endfunction

  task automatic modelUpdate();
    if (!rstN || !runEn) begin
      mPre = 0; mMs = 0; mPtr = 0; mRep = 0; expPulse = 0; expType = 0;
    end else begin
      bit tick, slot;
      int ivl;
      tick = (mPre == P - 1);
      ivl  = (intervalMs == 0) ? 1 : int'(intervalMs);
      slot = tick && (mMs >= ivl - 1);
      mPre = tick ? 0 : mPre + 1;
      if (tick) mMs = slot ? 0 : mMs + 1;
      expPulse = 0; expType = 0;
      if (slot) begin
        int p;
        p = pickKind(mPtr, genSettings, ratioWord);
        if (p >= 0) begin
          if (!genSettings[1]) begin expPulse = 1; expType = p; end
          if (mRep + 1 >= fieldCnt(p, ratioWord)) begin mPtr = (p + 1) % 3; mRep = 0; end
          else begin mPtr = p; mRep = mRep + 1; end
        end
      end
    end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: predict, wait, compare away from the rising edge.
  task automatic step(input string tag);
    modelUpdate();
    @(negedge clk);
    check(trigPulse == expPulse, {tag, " pulse"}, int'(trigPulse), int'(expPulse));
    check(int'(trigType) == expType, {tag, " type"}, int'(trigType), expType);
    if (trigPulse) seen[trigType] = seen[trigType] + 1;
  endtask

  task automatic runFor(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic clearSeen();
    for (int i = 0; i < 3; i++) seen[i] = 0;
  endtask

  task automatic stopFor(input int n);
    runEn = 1'b0;
    runFor(n, "R1 stopped");
  endtask

  initial begin
    void'($urandom(32'd1234));
    clearSeen();
    runFor(4, "R1 reset");
    check(trigPulse == 1'b0 && trigType == 2'd0, "R1 reset outputs", int'(trigPulse), 0);
    rstN = 1'b1;
    runFor(3, "R1 idle");

    // R2 R4 R5: counts 2/1/3, all enabled, 2 ms -> 12 slots in 192 cycles
    genSettings = 8'h70; intervalMs = 10'd2;
    ratioWord = {1'b0, 5'd2, 5'd1, 5'd3};
    clearSeen(); runEn = 1'b1;
    runFor(2 * P - 1, "R2 first slot wait");
    check(seen[0] == 0, "R2 no early pulse", seen[0], 0);
    step("R2 first slot");
    check(trigPulse == 1'b1 && trigType == 2'd0, "R2 first pulse pedestal", int'(trigPulse), 1);
    runFor(2 * P * 11, "R4 R5 order and ratio");
    check(seen[0] == 4, "R5 pedestal share", seen[0], 4);
    check(seen[1] == 2, "R5 internal share", seen[1], 2);
    check(seen[2] == 6, "R4 external share", seen[2], 6);
    stopFor(3);

    // R3: interval 0 behaves as 1 ms
    intervalMs = 10'd0; clearSeen(); runEn = 1'b1;
    runFor(P * 10, "R3 zero interval");
    check(seen[0] + seen[1] + seen[2] == 10, "R3 slot count", seen[0] + seen[1] + seen[2], 10);
    stopFor(2);

    // R6: internal disabled, skipped without losing time
    genSettings = 8'h50; intervalMs = 10'd1; clearSeen(); runEn = 1'b1;
    runFor(P * 10, "R6 disabled kind");
    check(seen[1] == 0, "R6 internal silent", seen[1], 0);
    check(seen[0] + seen[2] == 10, "R6 no lost slots", seen[0] + seen[2], 10);
    stopFor(2);

    // R7: zero count for external
    genSettings = 8'h70; ratioWord = {1'b0, 5'd1, 5'd2, 5'd0}; clearSeen(); runEn = 1'b1;
    runFor(P * 9, "R7 zero count");
    check(seen[2] == 0, "R7 external silent", seen[2], 0);
    check(seen[0] == 3 && seen[1] == 6, "R7 split", seen[1], 6);
    stopFor(2);

    // R8: nothing eligible
    genSettings = 8'h0C; ratioWord = 16'h7fff; clearSeen(); runEn = 1'b1;
    runFor(P * 6, "R8 nothing eligible");
    check(seen[0] + seen[1] + seen[2] == 0, "R8 silent", seen[0] + seen[1] + seen[2], 0);
    stopFor(2);

    // R9: veto consumes slots, then release continues mid-sequence
    genSettings = 8'h72; ratioWord = {1'b0, 5'd1, 5'd1, 5'd1}; clearSeen(); runEn = 1'b1;
    runFor(P * 4, "R9 veto");
    check(seen[0] + seen[1] + seen[2] == 0, "R9 vetoed", seen[0] + seen[1] + seen[2], 0);
    genSettings = 8'h70;
    runFor(P, "R9 after veto");
    check(seen[1] == 1, "R9 sequence advanced", seen[1], 1);
    stopFor(2);

    // R10: stop mid-round, restart at pedestal with fresh timer
    ratioWord = {1'b0, 5'd1, 5'd3, 5'd1}; intervalMs = 10'd1; runEn = 1'b1;
    runFor(P * 2 + 3, "R10 partial run");
    stopFor(1);
    clearSeen(); runEn = 1'b1;
    runFor(P, "R10 restart");
    check(seen[0] == 1, "R10 restart at pedestal", seen[0], 1);
    stopFor(2);

    // Random configurations, with occasional changes while running (R11 via model)
    for (int t = 0; t < 40; t++) begin
      genSettings = 8'($urandom) & 8'hf3;
      if ($urandom_range(0, 7) == 0) genSettings[1] = 1'b1;
      intervalMs = 10'($urandom_range(0, 3));
      ratioWord = {1'b0, 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3))};
      runEn = 1'b1;
      runFor(120, "R11 random run");
      if ($urandom_range(0, 1) == 1) begin
        ratioWord[4:0] = 5'($urandom_range(0, 3));
        genSettings[5] = ~genSettings[5];
        runFor(100, "R6 R5 live change");
      end
      stopFor($urandom_range(1, 3));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule